// File: doc/BRIEF.md
# System control block: remap, pause and reset cause

This peripheral sits on a simple synchronous register bus (select, write enable, 8-bit byte offset, 32-bit write and read data) and gathers four small system-control duties. A write to the pause location asks the processor to stop and wait for an interrupt. The block holds that request until the interrupt-pending input goes high. A read-only identification word reports whether more identification data is present. A reset-cause register records whether the last reset came from power-on. It also holds a parameterised set of general flags. Software changes single bits of it through separate write-one-to-set and write-one-to-clear locations, so no read-modify-write is needed.

A fourth location ends the boot-time memory remap. The remap flag goes to the system address decoder. Either reset returns it to active. A power-on reset also sets the power-on flag and clears the general flags. A warm reset leaves the whole reset-cause register as it was. The clock gating and the remap multiplexer are outside this block.

Top module: `sysctl_remap_pause`

## Requirements
- R1: After a power-on reset, `pause_req` is 0, `remap_active` is 1, `bus_rdata` is 0, and the reset-cause register (offset 0x30) reads 1: power-on flag in bit 0, general flags in bits 1..N_GEN all 0.
- R2: A read of offset 0x10 returns the identification word `{ID_DETAIL, |ID_DETAIL}`, so bit 0 is 1 exactly when further identification bits exist (default word 0x0000014B). Writes to 0x10 change nothing.
- R3: A write to offset 0x30 sets each general flag whose data bit is 1 and leaves the others alone. Data bit 0 has no effect, so software can never set the power-on flag.
- R4: A write to offset 0x34 clears each status bit whose data bit is 1, the power-on flag included, and leaves bits whose data bit is 0 unchanged.
- R5: Status bits above bit N_GEN read as 0.
- R6: A pause write (any data to offset 0x00) made while `irq_pending` is low raises `pause_req` on the next cycle. `pause_req` stays high until `irq_pending` is high, and drops combinationally in that same cycle.
- R7: A pause write made while `irq_pending` is high does not raise `pause_req`.
- R8: A write to offset 0x20 clears `remap_active`. It stays 0 until a reset of either kind sets it again.
- R9: A warm reset sets `remap_active`, drops any pause request, and keeps both the power-on flag and the general flags unchanged.
- R10: Read data is registered. `bus_rdata` shows the addressed value one cycle after a read, and is 0 in the cycle after any non-read. Reads of offsets 0x00, 0x20, 0x34 or any unmapped offset return 0.
- R11: A second pause write made while a pause is already pending keeps `pause_req` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| warm_n | input | 1 | Warm reset, asynchronous, active low |
| bus_sel | input | 1 | Access strobe for this block |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_pending | input | 1 | Any interrupt pending; releases the pause |
| pause_req | output | 1 | Wait-for-interrupt request to the clock controller |
| remap_active | output | 1 | Boot remap still in force |

## Verification
The case that is hardest to reach from the ports is a warm reset that arrives after software has cleared the power-on flag and set some general flags. It only shows whether the flags survive because of that earlier bit-wise history. The stimulus first clears bit 0 and sets a mix of general flags. It then tries to set bit 0 again, which must fail. It clears one general flag, asserts the warm reset, and reads the register back. Pause is driven with `irq_pending` both low and high at the moment of the write, and with a repeated write while already paused, so that the release edge and the blocked request are each observed.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_PAUSE   = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_IDENT   = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_UNMAP   = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_CAUSE   = 8'h30;
  localparam logic [BUS_AW-1:0] OFS_CAUSECL = 8'h34;

  typedef struct packed {
    logic pause_wr;
    logic unmap_wr;
    logic cause_set_wr;
    logic cause_clr_wr;
    logic rd_ident;
    logic rd_cause;
    logic rd_any;
  } bus_ev_t;

  // Pause state update: a request is held until an interrupt is seen.
  function automatic logic pause_next(input logic held, input logic trig,
                                      input logic irq);
    return (held | trig) & ~irq;
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned AW = BUS_AW
) (
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] addr,
  output bus_ev_t       ev
);
  logic wr, rd;

  assign wr = sel & we;
  assign rd = sel & ~we;

  always_comb begin
    ev              = '0;
    ev.rd_any       = rd;
    ev.pause_wr     = wr && (addr == OFS_PAUSE);
    ev.unmap_wr     = wr && (addr == OFS_UNMAP);
    ev.cause_set_wr = wr && (addr == OFS_CAUSE);
    ev.cause_clr_wr = wr && (addr == OFS_CAUSECL);
    ev.rd_ident     = rd && (addr == OFS_IDENT);
    ev.rd_cause     = rd && (addr == OFS_CAUSE);
  end
endmodule

// File: rtl/sysctl_cause.sv
module sysctl_cause #(
  parameter int unsigned N_GEN = 3,
  localparam int unsigned SW   = N_GEN + 1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          set_wr,
  input  logic          clr_wr,
  input  logic [SW-1:0] wdata,
  output logic [SW-1:0] cause,
  output logic          por_flag
);
  // Clear wins over set when both hit one bit.
  function automatic logic [SW-1:0] flags_next(input logic [SW-1:0] cur,
                                               input logic [SW-1:0] set_m,
                                               input logic [SW-1:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

  logic [SW-1:0] set_m, clr_m, nxt;

  assign set_m = set_wr ? {wdata[SW-1:1], 1'b0} : '0;
  assign clr_m = clr_wr ? wdata : '0;
  assign nxt   = flags_next(cause, set_m, clr_m);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) por_flag <= 1'b1;
    else        por_flag <= nxt[0];
  end

  generate
    if (N_GEN > 0) begin : g_gen
      logic [N_GEN-1:0] gen_q;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) gen_q <= '0;
        else        gen_q <= nxt[SW-1:1];
      end
      assign cause = {gen_q, por_flag};
    end else begin : g_nogen
      assign cause = por_flag;
    end
  endgenerate
endmodule

// File: rtl/sysctl_pause.sv
module sysctl_pause
  import sysctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic irq,
  output logic held,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= pause_next(held, trig, irq);
  end

  assign req = held & ~irq;
endmodule

// File: rtl/sysctl_remap.sv
module sysctl_remap (
  input  logic clk,
  input  logic rst_n,
  input  logic unmap_wr,
  output logic active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        active <= 1'b1;
    else if (unmap_wr) active <= 1'b0;
  end
endmodule

// File: rtl/sysctl_remap_pause.sv
module sysctl_remap_pause
  import sysctl_pkg::*;
#(
  parameter int unsigned N_GEN            = 3,
  parameter logic [BUS_DW-1:1] ID_DETAIL = 31'h0000_00A5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic              irq_pending,
  output logic              pause_req,
  output logic              remap_active
);
  localparam int unsigned SW = N_GEN + 1;
  localparam logic [BUS_DW-1:0] ID_WORD = {ID_DETAIL, |ID_DETAIL};

  bus_ev_t       ev;
  logic          rst_any_n;
  logic [SW-1:0] cause;
  logic          por_flag;
  logic          pause_held;
  logic [BUS_DW-1:0] rd_val;

  // Named event wires for the checker.
  logic ev_pause_wr, ev_unmap_wr, ev_set_wr, ev_clr_wr;

  assign rst_any_n   = por_n & warm_n;
  assign ev_pause_wr = ev.pause_wr;
  assign ev_unmap_wr = ev.unmap_wr;
  assign ev_set_wr   = ev.cause_set_wr;
  assign ev_clr_wr   = ev.cause_clr_wr;

  sysctl_decode #(.AW(BUS_AW)) u_dec (
    .sel (bus_sel),
    .we  (bus_we),
    .addr(bus_addr),
    .ev  (ev)
  );

  sysctl_cause #(.N_GEN(N_GEN)) u_cause (
    .clk     (clk),
    .por_n   (por_n),
    .set_wr  (ev.cause_set_wr),
    .clr_wr  (ev.cause_clr_wr),
    .wdata   (bus_wdata[SW-1:0]),
    .cause   (cause),
    .por_flag(por_flag)
  );

  sysctl_pause u_pause (
    .clk  (clk),
    .rst_n(rst_any_n),
    .trig (ev.pause_wr),
    .irq  (irq_pending),
    .held (pause_held),
    .req  (pause_req)
  );

  sysctl_remap u_remap (
    .clk     (clk),
    .rst_n   (rst_any_n),
    .unmap_wr(ev.unmap_wr),
    .active  (remap_active)
  );

  always_comb begin
    rd_val = '0;
    if (ev.rd_ident)      rd_val = ID_WORD;
    else if (ev.rd_cause) rd_val[SW-1:0] = cause;
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) bus_rdata <= '0;
    else            bus_rdata <= rd_val;
  end
endmodule

// File: rtl/sysctl_remap_pause_chk.sv
module sysctl_remap_pause_chk #(
  parameter int unsigned N_GEN = 3,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 8
) (
  input logic          clk,
  input logic          rst_any_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic          irq_pending,
  input logic          pause_req,
  input logic          remap_active,
  input logic          ev_pause_wr,
  input logic          ev_unmap_wr,
  input logic          ev_set_wr,
  input logic          pause_held,
  input logic          por_flag
);
  assert_pause_rise_R6: assert property (@(posedge clk) disable iff (!rst_any_n)
    ev_pause_wr && !irq_pending |=> pause_held);

  assert_pause_drop_R6: assert property (@(posedge clk) disable iff (!rst_any_n)
    irq_pending |-> !pause_req);

  assert_pause_blocked_R7: assert property (@(posedge clk) disable iff (!rst_any_n)
    !pause_held && irq_pending |=> !pause_held);

  assert_pause_keep_R11: assert property (@(posedge clk) disable iff (!rst_any_n)
    pause_held && !irq_pending |=> pause_held);

  assert_por_no_set_R3: assert property (@(posedge clk) disable iff (!rst_any_n)
    ev_set_wr |=> $stable(por_flag));

  assert_unmap_R8: assert property (@(posedge clk) disable iff (!rst_any_n)
    ev_unmap_wr |=> !remap_active);

  assert_unmap_sticky_R8: assert property (@(posedge clk) disable iff (!rst_any_n)
    !remap_active |=> !remap_active);

  assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_any_n)
    !(bus_sel && !bus_we) |=> bus_rdata == '0);

  assert_cause_upper_R5: assert property (@(posedge clk) disable iff (!rst_any_n)
    bus_sel && !bus_we && bus_addr == 8'h30 |=> (bus_rdata >> (N_GEN + 1)) == '0);
endmodule

bind sysctl_remap_pause sysctl_remap_pause_chk #(
  .N_GEN(N_GEN), .DW(32), .AW(8)
) u_chk (
  .clk         (clk),
  .rst_any_n   (rst_any_n),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .irq_pending (irq_pending),
  .pause_req   (pause_req),
  .remap_active(remap_active),
  .ev_pause_wr (ev_pause_wr),
  .ev_unmap_wr (ev_unmap_wr),
  .ev_set_wr   (ev_set_wr),
  .pause_held  (pause_held),
  .por_flag    (por_flag)
);

// File: tb/sysctl_remap_pause_tb.sv
module sysctl_remap_pause_tb;
  localparam int NG = 3;
  localparam logic [31:0] ID_EXP = 32'h0000_014B;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, warm_n = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_pending = 1'b0;
  logic        pause_req, remap_active;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural model state
  bit        m_por = 1, m_remap = 1, m_pause = 0;
  bit [NG:1] m_gen = '0;
  bit [31:0] m_rd = '0;

  always #2.5 clk = ~clk;

  sysctl_remap_pause u_dut (
    .clk(clk), .por_n(por_n), .warm_n(warm_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pending(irq_pending), .pause_req(pause_req), .remap_active(remap_active)
  );

  always @(posedge clk) begin
    cycles++;
    if (!por_n) begin
      m_por = 1; m_gen = '0; m_remap = 1; m_pause = 0; m_rd = '0;
    end else if (!warm_n) begin
      m_remap = 1; m_pause = 0; m_rd = '0;
    end else begin
      bit [31:0] r;
      r = '0;
      if (bus_sel && !bus_we) begin
        if (bus_addr == 8'h10) r = ID_EXP;
        if (bus_addr == 8'h30) r = {28'd0, m_gen, m_por};
      end
      m_pause = (m_pause || (bus_sel && bus_we && bus_addr == 8'h00)) && !irq_pending;
      if (bus_sel && bus_we) begin
        if (bus_addr == 8'h20) m_remap = 0;
        if (bus_addr == 8'h30) m_gen = m_gen | bus_wdata[NG:1];
        if (bus_addr == 8'h34) begin
          m_gen = m_gen & ~bus_wdata[NG:1];
          if (bus_wdata[0]) m_por = 0;
        end
      end
      m_rd = r;
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) if (!done) begin
    check("pause_req", {31'd0, pause_req}, {31'd0, m_pause && !irq_pending});
    check("remap_active", {31'd0, remap_active}, {31'd0, m_remap});
    check("bus_rdata", bus_rdata, m_rd);
  end

  task automatic idle(int n);
    repeat (n) begin
      @(posedge clk); #1;
      bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  // read, then a directed check on the value seen one cycle later
  task automatic rd(logic [7:0] a, logic [31:0] exp);
    @(posedge clk); #1;
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 0;
    check($sformatf("read %h", a), bus_rdata, exp);
  endtask

  initial begin
    // R1 reset state
    cur_req = "R1";
    idle(3);
    #1 por_n = 1;
    idle(2);
    check("reset pause_req", {31'd0, pause_req}, 32'd0);
    check("reset remap", {31'd0, remap_active}, 32'd1);
    rd(8'h30, 32'h1);

    // R2 identification, writes ignored
    cur_req = "R2";
    rd(8'h10, ID_EXP);
    wr(8'h10, 32'h0);
    rd(8'h10, ID_EXP);
    rd(8'h30, 32'h1);

    // R4 clear power-on flag; R3 set cannot bring it back
    cur_req = "R4";
    wr(8'h34, 32'h1);
    rd(8'h30, 32'h0);
    cur_req = "R3";
    wr(8'h30, 32'h1);
    rd(8'h30, 32'h0);
    wr(8'h30, 32'h0000_000A);
    rd(8'h30, 32'hA);
    wr(8'h30, 32'h0000_0004);
    rd(8'h30, 32'hE);
    // R5 upper bits never appear
    cur_req = "R5";
    wr(8'h30, 32'hFFFF_FFF0);
    rd(8'h30, 32'hE);
    // R4 clear one flag, others kept; zero data no effect
    cur_req = "R4";
    wr(8'h34, 32'h0000_0004);
    rd(8'h30, 32'hA);
    wr(8'h34, 32'h0);
    rd(8'h30, 32'hA);

    // R10 reserved reads and idle data
    cur_req = "R10";
    rd(8'h00, 32'h0);
    rd(8'h20, 32'h0);
    rd(8'h34, 32'h0);
    rd(8'h44, 32'h0);

    // R6 pause and release
    cur_req = "R6";
    wr(8'h00, 32'h0);
    check("pause high", {31'd0, pause_req}, 32'd1);
    idle(4);
    check("pause held", {31'd0, pause_req}, 32'd1);
    // R11 repeated pause write
    cur_req = "R11";
    wr(8'h00, 32'h5);
    idle(2);
    check("pause still held", {31'd0, pause_req}, 32'd1);
    cur_req = "R6";
    #1 irq_pending = 1;
    #0.5 check("pause drops with irq", {31'd0, pause_req}, 32'd0);
    idle(2);
    irq_pending = 0;
    idle(1);
    check("pause gone after irq", {31'd0, pause_req}, 32'd0);

    // R7 pause blocked by pending interrupt
    cur_req = "R7";
    irq_pending = 1;
    wr(8'h00, 32'h0);
    irq_pending = 0;
    idle(3);
    check("blocked pause", {31'd0, pause_req}, 32'd0);

    // R8 remap end is sticky
    cur_req = "R8";
    wr(8'h20, 32'h0);
    check("remap cleared", {31'd0, remap_active}, 32'd0);
    wr(8'h20, 32'h0);
    idle(3);
    check("remap sticky", {31'd0, remap_active}, 32'd0);

    // R9 warm reset: remap back, flags kept, pause dropped
    cur_req = "R9";
    wr(8'h00, 32'h0);
    @(negedge clk) warm_n = 0;
    idle(2);
    @(negedge clk) warm_n = 1;
    idle(1);
    check("warm remap", {31'd0, remap_active}, 32'd1);
    check("warm pause", {31'd0, pause_req}, 32'd0);
    rd(8'h30, 32'hA);

    // R1 power-on reset restores flags
    cur_req = "R1";
    wr(8'h20, 32'h0);
    @(negedge clk) por_n = 0;
    idle(2);
    @(negedge clk) por_n = 1;
    idle(1);
    check("por remap", {31'd0, remap_active}, 32'd1);
    rd(8'h30, 32'h1);

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule